// File: doc/BRIEF.md
# Wave-Ordered Store Buffer Arbiter

This block sits between the processing-element clusters and a small pool of store buffers. Each store buffer serves a group of four clusters (64 functional units). Every dynamic wave is tied to exactly one buffer, and every memory request of that wave ends up at that buffer. A request enters with its wave number, the buffer closest to the requester (its origin) and an operation bit. The block looks the wave up in a direct-indexed wave-to-buffer table. A hit forwards the request to the recorded owner. A miss claims the entry for a free buffer: the origin if it is idle, otherwise the next idle buffer in ring order. Lookup and claim happen in the same cycle.

The block also moves a permission token in wave order. When a buffer reports that its wave has finished, the block clears that wave's table entry and frees the buffer. It then sends a one-cycle proceed pulse to the buffer that owns the next wave. If nobody has claimed the next wave yet, the token waits and the pulse goes out when the claim arrives. In this way the logically central store buffer moves from buffer to buffer across the array.

Top module: `wsb_arbiter`

## Requirements
- R1: After reset, rsp_valid_o and proceed_o are 0, every table entry is empty, and the token belongs to wave 0 and is waiting for a claim.
- R2: A response appears exactly one cycle after a request with req_valid_i high. It echoes the request's wave and operation bit. A cycle with no request gives rsp_valid_o low one cycle later.
- R3: If a request's wave is in the table, rsp_kind_o is 0 (forward) and rsp_buf_o is the recorded owner, whichever origin sent it. If the wave misses and the origin buffer is idle, rsp_kind_o is 1 (local claim), rsp_buf_o is the origin, and the entry is written.
- R4: If the wave misses and the origin is busy, the block picks the first idle buffer among origin+1, origin+2, … (modulo the buffer count). It answers with rsp_kind_o = 2 (remote claim) and that buffer. A buffer holds at most one wave.
- R5: If the wave misses and either its table slot holds a different valid wave or every buffer is busy, rsp_kind_o is 3 (blocked) and rsp_buf_o is the origin. Neither the table nor occupancy changes.
- R6: The table slot of a wave is given by its low MAP_IDX_W bits. Each slot stores a valid bit, the full wave number and the owner.
- R7: When the waiting token wave is claimed, proceed_o pulses the claiming buffer's bit in the same cycle as the claim's response.
- R8: done_i[b] from a busy buffer frees b and clears its wave's entry. If wave+1 is in the table, proceed_o pulses its owner one cycle later. Otherwise the token waits for wave+1 to be claimed.
- R9: done_i[b] from an idle buffer has no effect: no proceed pulse, and no change to the table or the token.
- R10: proceed_o never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_wave_i | input | WAVE_W | Wave number of the request |
| req_origin_i | input | BUF_W | Buffer nearest the requester |
| req_op_i | input | 1 | Operation bit (1 = store, 0 = load) |
| done_i | input | NUM_BUF | Per-buffer wave-finished pulse |
| rsp_valid_o | output | 1 | Response valid |
| rsp_kind_o | output | 2 | 0 forward, 1 local claim, 2 remote claim, 3 blocked |
| rsp_buf_o | output | BUF_W | Buffer the request goes to (origin when blocked) |
| rsp_wave_o | output | WAVE_W | Echoed wave number |
| rsp_op_o | output | 1 | Echoed operation bit |
| proceed_o | output | NUM_BUF | Per-buffer one-cycle permission pulse |

## Verification
The assertions assume that done_i has at most one bit set per cycle. They also assume that no request names a wave whose owner reports done in that same cycle. Origins are assumed to be below NUM_BUF. The stimulus respects these assumptions: it issues at most one done pulse per step and keeps requests and completions in separate cycles. It uses only origins 0 to 3 with the default four buffers. Completion pulses go out in wave order, plus one deliberate pulse from an idle buffer.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  typedef enum logic [1:0] {
    RSP_FWD          = 2'd0,
    RSP_CLAIM_LOCAL  = 2'd1,
    RSP_CLAIM_REMOTE = 2'd2,
    RSP_BLOCKED      = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/wsb_map.sv
module wsb_map #(
  parameter int IDX_W  = 2,
  parameter int WAVE_W = 8,
  parameter int BUF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WAVE_W-1:0] rd_wave_i,
  output logic              rd_hit_o,
  output logic              rd_conflict_o,
  output logic [BUF_W-1:0]  rd_buf_o,
  input  logic [WAVE_W-1:0] lk_wave_i,
  output logic              lk_hit_o,
  output logic [BUF_W-1:0]  lk_buf_o,
  input  logic              wr_en_i,
  input  logic [WAVE_W-1:0] wr_wave_i,
  input  logic [BUF_W-1:0]  wr_buf_i,
  input  logic              clr_en_i,
  input  logic [WAVE_W-1:0] clr_wave_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]             vld_q;
  logic [DEPTH-1:0][WAVE_W-1:0] tag_q;
  logic [DEPTH-1:0][BUF_W-1:0]  own_q;

  logic [IDX_W-1:0] rd_idx, lk_idx, wr_idx, clr_idx;
  assign rd_idx  = rd_wave_i[IDX_W-1:0];
  assign lk_idx  = lk_wave_i[IDX_W-1:0];
  assign wr_idx  = wr_wave_i[IDX_W-1:0];
  assign clr_idx = clr_wave_i[IDX_W-1:0];

  assign rd_hit_o      = vld_q[rd_idx] && (tag_q[rd_idx] == rd_wave_i);
  assign rd_conflict_o = vld_q[rd_idx] && (tag_q[rd_idx] != rd_wave_i);
  assign rd_buf_o      = own_q[rd_idx];
  assign lk_hit_o      = vld_q[lk_idx] && (tag_q[lk_idx] == lk_wave_i);
  assign lk_buf_o      = own_q[lk_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      tag_q <= '0;
      own_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wr_en_i && wr_idx == IDX_W'(e)) begin
          vld_q[e] <= 1'b1;
          tag_q[e] <= wr_wave_i;
          own_q[e] <= wr_buf_i;
        end else if (clr_en_i && clr_idx == IDX_W'(e) && tag_q[e] == clr_wave_i) begin
          vld_q[e] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wsb_alloc.sv
module wsb_alloc #(
  parameter int NUM_BUF = 4,
  parameter int WAVE_W  = 8,
  parameter int BUF_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BUF_W-1:0]   origin_i,
  output logic               free_ok_o,
  output logic [BUF_W-1:0]   free_buf_o,
  input  logic               claim_en_i,
  input  logic [BUF_W-1:0]   claim_buf_i,
  input  logic [WAVE_W-1:0]  claim_wave_i,
  input  logic [NUM_BUF-1:0] done_i,
  output logic               done_ok_o,
  output logic [WAVE_W-1:0]  done_wave_o
);
  logic [NUM_BUF-1:0]             busy_q;
  logic [NUM_BUF-1:0][WAVE_W-1:0] wave_q;
  logic [BUF_W-1:0]               done_buf;

  // ring search from origin; descending loop leaves the nearest idle buffer
  always_comb begin
    int cand;
    free_ok_o  = 1'b0;
    free_buf_o = origin_i;
    for (int k = NUM_BUF - 1; k >= 0; k--) begin
      cand = (int'(origin_i) + k) % NUM_BUF;
      if (!busy_q[cand]) begin
        free_ok_o  = 1'b1;
        free_buf_o = BUF_W'(cand);
      end
    end
  end

  // completions from idle buffers are dropped here
  always_comb begin
    done_ok_o = 1'b0;
    done_buf  = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (done_i[i] && busy_q[i]) begin
        done_ok_o = 1'b1;
        done_buf  = BUF_W'(i);
      end
    end
  end
  assign done_wave_o = wave_q[done_buf];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      wave_q <= '0;
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (claim_en_i && claim_buf_i == BUF_W'(i)) begin
          busy_q[i] <= 1'b1;
          wave_q[i] <= claim_wave_i;
        end else if (done_ok_o && done_buf == BUF_W'(i)) begin
          busy_q[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wsb_token.sv
module wsb_token #(
  parameter int NUM_BUF = 4,
  parameter int WAVE_W  = 8,
  parameter int BUF_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_ok_i,
  input  logic [WAVE_W-1:0]  done_wave_i,
  output logic [WAVE_W-1:0]  succ_wave_o,
  input  logic               succ_hit_i,
  input  logic [BUF_W-1:0]   succ_buf_i,
  input  logic               claim_en_i,
  input  logic [WAVE_W-1:0]  claim_wave_i,
  input  logic [BUF_W-1:0]   claim_buf_i,
  output logic [NUM_BUF-1:0] proceed_o
);
  logic [WAVE_W-1:0]  tok_wave_q, tok_wave_d;
  logic               tok_wait_q, tok_wait_d;
  logic [NUM_BUF-1:0] pro_d;

  assign succ_wave_o = done_wave_i + WAVE_W'(1);

  always_comb begin
    tok_wave_d = tok_wave_q;
    tok_wait_d = tok_wait_q;
    pro_d      = '0;
    if (done_ok_i) begin
      tok_wave_d = succ_wave_o;
      tok_wait_d = !succ_hit_i;
      if (succ_hit_i) pro_d[succ_buf_i] = 1'b1;
    end
    // claim checked against the post-completion token
    if (claim_en_i && tok_wait_d && claim_wave_i == tok_wave_d) begin
      pro_d[claim_buf_i] = 1'b1;
      tok_wait_d         = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_wave_q <= '0;
      tok_wait_q <= 1'b1;
      proceed_o  <= '0;
    end else begin
      tok_wave_q <= tok_wave_d;
      tok_wait_q <= tok_wait_d;
      proceed_o  <= pro_d;
    end
  end
endmodule

// File: rtl/wsb_arbiter.sv
module wsb_arbiter #(
  parameter int NUM_BUF   = 4,
  parameter int WAVE_W    = 8,
  parameter int MAP_IDX_W = 2,
  parameter int BUF_W     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [WAVE_W-1:0]  req_wave_i,
  input  logic [BUF_W-1:0]   req_origin_i,
  input  logic               req_op_i,
  input  logic [NUM_BUF-1:0] done_i,
  output logic               rsp_valid_o,
  output logic [1:0]         rsp_kind_o,
  output logic [BUF_W-1:0]   rsp_buf_o,
  output logic [WAVE_W-1:0]  rsp_wave_o,
  output logic               rsp_op_o,
  output logic [NUM_BUF-1:0] proceed_o
);
  import wsb_pkg::*;

  logic              rd_hit, rd_conflict, lk_hit;
  logic [BUF_W-1:0]  rd_buf, lk_buf, free_buf;
  logic              free_ok, claim_en, done_ok;
  logic [WAVE_W-1:0] done_wave, succ_wave;
  rsp_kind_e         kind_d;
  logic [BUF_W-1:0]  buf_d;

  assign claim_en = req_valid_i && !rd_hit && !rd_conflict && free_ok;

  always_comb begin
    if (rd_hit) begin
      kind_d = RSP_FWD;
      buf_d  = rd_buf;
    end else if (claim_en) begin
      kind_d = (free_buf == req_origin_i) ? RSP_CLAIM_LOCAL : RSP_CLAIM_REMOTE;
      buf_d  = free_buf;
    end else begin
      kind_d = RSP_BLOCKED;
      buf_d  = req_origin_i;
    end
  end

  wsb_map #(.IDX_W(MAP_IDX_W), .WAVE_W(WAVE_W), .BUF_W(BUF_W)) u_map (
    .clk_i, .rst_ni,
    .rd_wave_i     (req_wave_i),
    .rd_hit_o      (rd_hit),
    .rd_conflict_o (rd_conflict),
    .rd_buf_o      (rd_buf),
    .lk_wave_i     (succ_wave),
    .lk_hit_o      (lk_hit),
    .lk_buf_o      (lk_buf),
    .wr_en_i       (claim_en),
    .wr_wave_i     (req_wave_i),
    .wr_buf_i      (free_buf),
    .clr_en_i      (done_ok),
    .clr_wave_i    (done_wave)
  );

  wsb_alloc #(.NUM_BUF(NUM_BUF), .WAVE_W(WAVE_W), .BUF_W(BUF_W)) u_alloc (
    .clk_i, .rst_ni,
    .origin_i     (req_origin_i),
    .free_ok_o    (free_ok),
    .free_buf_o   (free_buf),
    .claim_en_i   (claim_en),
    .claim_buf_i  (free_buf),
    .claim_wave_i (req_wave_i),
    .done_i       (done_i),
    .done_ok_o    (done_ok),
    .done_wave_o  (done_wave)
  );

  wsb_token #(.NUM_BUF(NUM_BUF), .WAVE_W(WAVE_W), .BUF_W(BUF_W)) u_token (
    .clk_i, .rst_ni,
    .done_ok_i    (done_ok),
    .done_wave_i  (done_wave),
    .succ_wave_o  (succ_wave),
    .succ_hit_i   (lk_hit),
    .succ_buf_i   (lk_buf),
    .claim_en_i   (claim_en),
    .claim_wave_i (req_wave_i),
    .claim_buf_i  (free_buf),
    .proceed_o    (proceed_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_kind_o  <= '0;
      rsp_buf_o   <= '0;
      rsp_wave_o  <= '0;
      rsp_op_o    <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_kind_o <= kind_d;
        rsp_buf_o  <= buf_d;
        rsp_wave_o <= req_wave_i;
        rsp_op_o   <= req_op_i;
      end
    end
  end
endmodule

// File: rtl/wsb_arbiter_checker.sv
module wsb_arbiter_checker #(
  parameter int NUM_BUF = 4,
  parameter int WAVE_W  = 8,
  parameter int BUF_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [WAVE_W-1:0]  req_wave_i,
  input logic [BUF_W-1:0]   req_origin_i,
  input logic               req_op_i,
  input logic [NUM_BUF-1:0] done_i,
  input logic               rsp_valid_o,
  input logic [1:0]         rsp_kind_o,
  input logic [BUF_W-1:0]   rsp_buf_o,
  input logic [WAVE_W-1:0]  rsp_wave_o,
  input logic               rsp_op_o,
  input logic [NUM_BUF-1:0] proceed_o
);
  a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o && rsp_wave_o == $past(req_wave_i) && rsp_op_o == $past(req_op_i));

  a_r2_no_rsp_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r3_local_is_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd1) |-> rsp_buf_o == $past(req_origin_i));

  a_r4_remote_not_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd2) |-> rsp_buf_o != $past(req_origin_i));

  a_r5_blocked_names_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd3) |-> rsp_buf_o == $past(req_origin_i));

  a_r10_proceed_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(proceed_o));

  a_r8_proceed_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|proceed_o) |-> $past((|done_i) || req_valid_i));
endmodule

bind wsb_arbiter wsb_arbiter_checker #(
  .NUM_BUF(NUM_BUF), .WAVE_W(WAVE_W), .BUF_W(BUF_W)
) u_chk (.*);

// File: tb/tb_wsb_arbiter.sv
module tb_wsb_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int WW = 8;
  localparam int BW = 2;
  localparam int NVEC = 7;

  // {wave, origin, op, exp_kind, exp_buf, exp_proceed}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'd0, 2'd1, 1'b1, 2'd1, 2'd1, 4'b0010},  // R3 local claim, R7 token wave 0
    {8'd0, 2'd3, 1'b0, 2'd0, 2'd1, 4'b0000},  // R3 forward from other origin
    {8'd1, 2'd1, 1'b1, 2'd2, 2'd2, 4'b0000},  // R4 origin busy
    {8'd2, 2'd2, 1'b0, 2'd2, 2'd3, 4'b0000},  // R4
    {8'd3, 2'd3, 1'b1, 2'd2, 2'd0, 4'b0000},  // R4 wrap
    {8'd4, 2'd0, 1'b0, 2'd3, 2'd0, 4'b0000},  // R5 slot held by wave 0, R6
    {8'd1, 2'd0, 1'b1, 2'd0, 2'd2, 4'b0000}   // R3 forward
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [WW-1:0] req_wave_i = '0;
  logic [BW-1:0] req_origin_i = '0;
  logic          req_op_i = 1'b0;
  logic [NB-1:0] done_i = '0;
  logic          rsp_valid_o;
  logic [1:0]    rsp_kind_o;
  logic [BW-1:0] rsp_buf_o;
  logic [WW-1:0] rsp_wave_o;
  logic          rsp_op_o;
  logic [NB-1:0] proceed_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  wsb_arbiter #(.NUM_BUF(NB), .WAVE_W(WW), .MAP_IDX_W(2)) dut (.*);

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [WW-1:0] w, input logic [BW-1:0] o,
                      input logic op, input logic [NB-1:0] d);
    @(negedge clk_i);
    req_valid_i  = v;
    req_wave_i   = w;
    req_origin_i = o;
    req_op_i     = op;
    done_i       = d;
    @(posedge clk_i);
    #1;
  endtask

  task automatic req_chk(input string tag, input logic [WW-1:0] w, input logic [BW-1:0] o,
                         input int kind, input int bufn, input int pro);
    step(1'b1, w, o, 1'b1, '0);
    chk(tag, int'(rsp_valid_o), 1);
    chk(tag, int'(rsp_kind_o), kind);
    chk(tag, int'(rsp_buf_o), bufn);
    chk(tag, int'(proceed_o), pro);
  endtask

  task automatic done_chk(input string tag, input logic [NB-1:0] d, input int pro);
    step(1'b0, '0, '0, 1'b0, d);
    chk(tag, int'(proceed_o), pro);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 rsp_valid", int'(rsp_valid_o), 0);
    chk("R1 proceed", int'(proceed_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, VEC[i][18:11], VEC[i][10:9], VEC[i][8], '0);
      chk("R2 valid", int'(rsp_valid_o), 1);
      chk("R2 wave echo", int'(rsp_wave_o), int'(VEC[i][18:11]));
      chk("R2 op echo", int'(rsp_op_o), int'(VEC[i][8]));
      chk("R3/R4/R5 kind", int'(rsp_kind_o), int'(VEC[i][7:6]));
      chk("R3/R4/R5 buf", int'(rsp_buf_o), int'(VEC[i][5:4]));
      chk("R7 proceed", int'(proceed_o), int'(VEC[i][3:0]));
    end

    step(1'b0, '0, '0, 1'b0, '0);
    chk("R2 idle", int'(rsp_valid_o), 0);

    done_chk("R8 wave0 done to owner of wave1", 4'b0010, 4'b0100);
    req_chk("R6 slot freed, R4 remote", 8'd4, 2'd0, 2, 1, 0);
    done_chk("R8 wave1 done to owner of wave2", 4'b0100, 4'b1000);
    done_chk("R9 idle done ignored", 4'b0100, 4'b0000);
    req_chk("R5 slot conflict", 8'd6, 2'd0, 3, 0, 0);
    done_chk("R8 wave2 done", 4'b1000, 4'b0001);
    done_chk("R8 wave3 done", 4'b0001, 4'b0010);
    done_chk("R8 wave4 done, token held", 4'b0010, 4'b0000);
    req_chk("R8 held token released on claim", 8'd5, 2'd3, 1, 3, 4'b1000);

    @(negedge clk_i);
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    #1;
    chk("R1 rsp_valid mid-run", int'(rsp_valid_o), 0);
    chk("R1 proceed mid-run", int'(proceed_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    req_chk("R1 empty map and token", 8'd0, 2'd2, 1, 2, 4'b0100);

    step(1'b0, '0, '0, 1'b0, '0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule